// File: doc/BRIEF.md
# Switch Output Fault Supervisor

This block is the digital fault manager for a protected high-side switch with several output channels (two by default). Each channel has an on command from the host and debounced comparator flags for a severe short and for overtemperature. The supply has shared overvoltage and undervoltage flags, plus a separate flag that says the supply has climbed back above its recovery level. The block drives one gate enable per channel and an active-low fault line. It also keeps a sticky fault register that a status read snapshots and then clears.

Faults are released in different ways. A short or overtemperature latch holds its channel off until the flag is gone and the command has gone off and then on again. An overvoltage shutdown lifts by itself when the flag drops. A single configuration bit can turn overvoltage into a warning that only sets its status bit. An undervoltage latch is dropped on recovery if the channel command is off. If the command is on, the latch holds until the command goes off or an external retry pulse arrives. A supply-fail input or a power-on clear input wipes every latch and every status bit.

The status read is a plain strobe. The snapshot comes back on `rd_data` with a one-cycle `rd_valid` pulse, and there is no back-pressure: the reader must take it in that cycle.

Top module: `switch_fault_supervisor`

## Requirements
- R1: A severe-short flag on channel i forces `gate_en[i]` low in the same cycle and latches the channel off. It pulls `fault_n` low and sets status bit i from the next clock.
- R2: A short latch is released only after the flag is low, the command has been seen low for at least one clock while the flag is low, and the command then rises. The gate returns one clock after that rising edge. A rising edge without such an armed off phase does not release the latch.
- R3: An overtemperature flag on channel i behaves like a short under R1 and R2, but sets status bit NUM_CH+i.
- R4: While overvoltage protection is on (`ov_prot_off`=0), the overvoltage flag forces every gate low and `fault_n` low in the same cycle, and sets status bit 2*NUM_CH. The gates follow their commands again as soon as the flag drops, with no toggle.
- R5: With `ov_prot_off`=1 the overvoltage flag changes neither the gates nor `fault_n`, but it still sets status bit 2*NUM_CH.
- R6: The undervoltage flag forces every gate low and `fault_n` low in the same cycle, sets status bit 2*NUM_CH+1 and latches every channel.
- R7: On recovery (`uv_flag`=0 and `uv_recov`=1), a channel whose command is off drops its undervoltage latch at the next clock, so `fault_n` returns high. Status bit 2*NUM_CH+1 stays set until a read.
- R8: On recovery, a channel whose command is on stays latched off with `fault_n` low. It is released by the command going off, or by a `retry` pulse seen at a clock edge.
- R9: `supply_fail` or `pwr_on_clr` at a clock edge clears every latch and every status bit.
- R10: A read strobe yields `rd_valid`=1 and `rd_data` set to the status as it was before the read, one clock later. The read clears every status bit whose flag is low in the read cycle; a bit whose flag is high in that cycle stays set.
- R11: After reset the gates are low, `fault_n` is high and the status register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | NUM_CH | Per-channel on command |
| short_flag | input | NUM_CH | Per-channel severe-short comparator |
| ot_flag | input | NUM_CH | Per-channel overtemperature comparator |
| ov_flag | input | 1 | Supply overvoltage comparator |
| ov_prot_off | input | 1 | 1 turns overvoltage into a warning only |
| uv_flag | input | 1 | Supply undervoltage comparator |
| uv_recov | input | 1 | Supply above recovery level |
| retry | input | 1 | External retry pulse for undervoltage latches |
| supply_fail | input | 1 | Logic-supply failure, clears all faults |
| pwr_on_clr | input | 1 | Power-on clear, clears all faults |
| rd_strobe | input | 1 | Status read request |
| gate_en | output | NUM_CH | Per-channel gate enable |
| fault_n | output | 1 | Active-low fault line |
| flt_status | output | 2*NUM_CH+2 | Live sticky status register |
| rd_data | output | 2*NUM_CH+2 | Snapshot returned by the last read |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` |

## Verification
The bench builds the block with the default NUM_CH=2. Two channels are enough to latch one channel while its neighbour keeps running, and to release one channel's undervoltage latch while the other stays held. With this width the status bit positions are concrete values (short 1 and 2, overtemperature 4 and 8, overvoltage 16, undervoltage 32), so every read snapshot can be compared against a fixed number.

// File: rtl/sofs_pkg.sv
package sofs_pkg;
  // status register layout helpers
  function automatic int st_width(input int nch);
    return 2 * nch + 2;
  endfunction

  function automatic int ov_pos(input int nch);
    return 2 * nch;
  endfunction

  function automatic int uv_pos(input int nch);
    return 2 * nch + 1;
  endfunction
endpackage

// File: rtl/sofs_toggle_latch.sv
// Fault latch released by an armed off-then-on command toggle.
module sofs_toggle_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic flt,
  input  logic cmd,
  output logic lat
);
  logic lat_q, arm_q, cmd_q;
  logic rise;

  assign rise = cmd & ~cmd_q;
  assign lat  = lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      arm_q <= 1'b0;
      cmd_q <= 1'b0;
    end else begin
      cmd_q <= cmd;
      if (clr) begin
        lat_q <= 1'b0;
        arm_q <= 1'b0;
      end else if (flt) begin
        lat_q <= 1'b1;
        arm_q <= 1'b0;
      end else if (lat_q) begin
        if (arm_q && rise) begin
          lat_q <= 1'b0;
          arm_q <= 1'b0;
        end else if (!cmd) begin
          arm_q <= 1'b1;
        end
      end
    end
  end

  // flag always latches (R1, R3)
  assert_flag_latches_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flt && !clr) |=> lat_q);

  // a latch may only drop through clear or an armed rising edge with flag low (R2)
  assert_release_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat_q) |-> ($past(clr) || (!$past(flt) && $past(arm_q) && $past(cmd) && !$past(cmd_q))));
endmodule

// File: rtl/sofs_uv_hold.sv
// Per-channel undervoltage latch.
module sofs_uv_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic uv,
  input  logic recovered,
  input  logic cmd,
  input  logic retry,
  output logic lat
);
  logic lat_q;
  assign lat = lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   lat_q <= 1'b0;
    else if (clr)                                 lat_q <= 1'b0;
    else if (uv)                                  lat_q <= 1'b1;
    else if (lat_q && recovered && (!cmd || retry)) lat_q <= 1'b0;
  end

  assert_uv_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uv && !clr) |=> lat_q);

  // held while command stays on without retry (R8)
  assert_uv_hold_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clr && cmd && !retry) |=> lat_q);
endmodule

// File: rtl/sofs_status_bank.sv
// Sticky read-to-clear status register with snapshot port.
module sofs_status_bank #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set_vec,
  input  logic         rd,
  output logic [W-1:0] stat,
  output logic [W-1:0] rd_data,
  output logic         rd_valid
);
  logic [W-1:0] stat_q, snap_q;
  logic         vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      snap_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= rd;
      if (rd) snap_q <= stat_q;
      if (clr)     stat_q <= '0;
      else if (rd) stat_q <= set_vec;
      else         stat_q <= stat_q | set_vec;
    end
  end

  assign stat     = stat_q;
  assign rd_data  = snap_q;
  assign rd_valid = vld_q;

  assert_rd_snapshot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> (rd_valid && rd_data == $past(stat_q)));

  assert_live_bit_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !clr) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stat_q == '0));
endmodule

// File: rtl/switch_fault_supervisor.sv
module switch_fault_supervisor
  import sofs_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int ST_W = st_width(NUM_CH),
  localparam int OV_B = ov_pos(NUM_CH),
  localparam int UV_B = uv_pos(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cmd_on,
  input  logic [NUM_CH-1:0] short_flag,
  input  logic [NUM_CH-1:0] ot_flag,
  input  logic              ov_flag,
  input  logic              ov_prot_off,
  input  logic              uv_flag,
  input  logic              uv_recov,
  input  logic              retry,
  input  logic              supply_fail,
  input  logic              pwr_on_clr,
  input  logic              rd_strobe,
  output logic [NUM_CH-1:0] gate_en,
  output logic              fault_n,
  output logic [ST_W-1:0]   flt_status,
  output logic [ST_W-1:0]   rd_data,
  output logic              rd_valid
);
  logic              clr_all, ov_shut, recovered;
  logic [NUM_CH-1:0] sc_lat, ot_lat, uv_lat;
  logic [ST_W-1:0]   set_vec;

  assign clr_all   = supply_fail | pwr_on_clr;
  assign ov_shut   = ov_flag & ~ov_prot_off;
  assign recovered = ~uv_flag & uv_recov;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    sofs_toggle_latch u_sc (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .flt(short_flag[i]), .cmd(cmd_on[i]), .lat(sc_lat[i]));

    sofs_toggle_latch u_ot (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .flt(ot_flag[i]), .cmd(cmd_on[i]), .lat(ot_lat[i]));

    sofs_uv_hold u_uv (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .uv(uv_flag),
      .recovered(recovered), .cmd(cmd_on[i]), .retry(retry), .lat(uv_lat[i]));

    assign gate_en[i] = cmd_on[i] & ~sc_lat[i] & ~ot_lat[i] & ~uv_lat[i]
                      & ~short_flag[i] & ~ot_flag[i] & ~ov_shut & ~uv_flag;
  end

  assign fault_n = ~(|sc_lat | |ot_lat | |uv_lat | |short_flag | |ot_flag
                     | ov_shut | uv_flag);

  assign set_vec = {uv_flag, ov_flag, ot_flag, short_flag};

  sofs_status_bank #(.W(ST_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .set_vec(set_vec),
    .rd(rd_strobe), .stat(flt_status), .rd_data(rd_data), .rd_valid(rd_valid));

  assert_ov_shut_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && !ov_prot_off) |-> (gate_en == '0 && !fault_n));

  assert_uv_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |-> (gate_en == '0 && !fault_n));

  assert_short_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|short_flag) |-> !fault_n);

  assert_ov_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_flag && !clr_all) |=> flt_status[OV_B]);

  assert_uv_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_status[UV_B] && !rd_strobe && !clr_all) |=> flt_status[UV_B]);
endmodule

// File: tb/sim_switch_fault_supervisor.sv
module sim_switch_fault_supervisor;
  localparam int N = 2;
  localparam int W = 2 * N + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cmd_on = '0, short_flag = '0, ot_flag = '0;
  logic ov_flag = 0, ov_prot_off = 0, uv_flag = 0, uv_recov = 0, retry = 0;
  logic supply_fail = 0, pwr_on_clr = 0, rd_strobe = 0;
  logic [N-1:0] gate_en;
  logic fault_n, rd_valid;
  logic [W-1:0] flt_status, rd_data;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  switch_fault_supervisor #(.NUM_CH(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .short_flag(short_flag),
    .ot_flag(ot_flag), .ov_flag(ov_flag), .ov_prot_off(ov_prot_off),
    .uv_flag(uv_flag), .uv_recov(uv_recov), .retry(retry),
    .supply_fail(supply_fail), .pwr_on_clr(pwr_on_clr), .rd_strobe(rd_strobe),
    .gate_en(gate_en), .fault_n(fault_n), .flt_status(flt_status),
    .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance past one rising edge to the next falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_read(input logic [W-1:0] exp_snap);
    rd_strobe = 1; tick(); rd_strobe = 0; settle();
    chk("R10 valid", rd_valid, 1);
    chk("R10 snapshot", rd_data, exp_snap);
  endtask

  task automatic t_reset();
    rst_n = 0; tick(); tick(); rst_n = 1; tick(); settle();
    chk("R11 gates", gate_en, 0);
    chk("R11 fault_n", fault_n, 1);
    chk("R11 status", flt_status, 0);
  endtask

  task automatic t_short();
    cmd_on = 2'b11; tick(); settle();
    chk("R1 gates before", gate_en, 2'b11);
    short_flag = 2'b01; settle();
    chk("R1 gate off", gate_en, 2'b10);
    chk("R1 fault_n", fault_n, 0);
    tick(); settle();
    chk("R1 status", flt_status, 6'h01);
    short_flag = 0; tick(); tick(); settle();
    chk("R2 held no toggle", gate_en, 2'b10);
    cmd_on = 2'b10; tick();
    cmd_on = 2'b11; settle();
    chk("R2 not yet", gate_en, 2'b10);
    tick(); settle();
    chk("R2 released", gate_en, 2'b11);
    chk("R2 fault_n", fault_n, 1);
    chk("R2 status sticky", flt_status, 6'h01);
    do_read(6'h01);
    chk("R10 cleared", flt_status, 0);
  endtask

  task automatic t_unarmed();
    short_flag = 2'b10; tick();
    cmd_on = 2'b01; tick();
    short_flag = 0; cmd_on = 2'b11; tick(); tick(); settle();
    chk("R2 unarmed rise", gate_en, 2'b01);
    cmd_on = 2'b01; tick(); cmd_on = 2'b11; tick(); tick(); settle();
    chk("R2 armed rise", gate_en, 2'b11);
    do_read(6'h02);
  endtask

  task automatic t_ot();
    ot_flag = 2'b01; settle();
    chk("R3 gate off", gate_en, 2'b10);
    tick(); ot_flag = 0; settle();
    chk("R3 status", flt_status, 6'h04);
    chk("R3 fault_n", fault_n, 0);
    cmd_on = 2'b10; tick(); cmd_on = 2'b11; tick(); tick(); settle();
    chk("R3 release", gate_en, 2'b11);
    do_read(6'h04);
  endtask

  task automatic t_ov_on();
    ov_flag = 1; settle();
    chk("R4 gates off", gate_en, 0);
    chk("R4 fault_n", fault_n, 0);
    tick(); settle();
    chk("R4 status", flt_status, 6'h10);
    ov_flag = 0; settle();
    chk("R4 self release", gate_en, 2'b11);
    chk("R4 fault_n back", fault_n, 1);
    do_read(6'h10);
    chk("R10 ov cleared", flt_status, 0);
  endtask

  task automatic t_ov_off();
    ov_prot_off = 1; ov_flag = 1; settle();
    chk("R5 gates kept", gate_en, 2'b11);
    chk("R5 fault_n kept", fault_n, 1);
    tick(); settle();
    chk("R5 warning bit", flt_status, 6'h10);
    do_read(6'h10);
    chk("R10 live bit kept", flt_status, 6'h10);
    ov_flag = 0; tick();
    do_read(6'h10);
    chk("R5 cleared after flag gone", flt_status, 0);
    ov_prot_off = 0;
  endtask

  task automatic t_uv_cmd_off();
    cmd_on = 0; uv_flag = 1; settle();
    chk("R6 fault_n", fault_n, 0);
    tick(); settle();
    chk("R6 status", flt_status, 6'h20);
    uv_flag = 0; uv_recov = 1; tick(); settle();
    chk("R7 fault_n high", fault_n, 1);
    chk("R7 bit kept", flt_status, 6'h20);
    do_read(6'h20);
    chk("R7 bit read", flt_status, 0);
  endtask

  task automatic t_uv_cmd_on();
    cmd_on = 2'b11; uv_recov = 0; uv_flag = 1; settle();
    chk("R6 gates off", gate_en, 0);
    tick(); uv_flag = 0; uv_recov = 1; tick(); tick(); settle();
    chk("R8 held", gate_en, 0);
    chk("R8 fault_n low", fault_n, 0);
    cmd_on = 2'b10; tick(); cmd_on = 2'b11; settle();
    chk("R8 ch0 by toggle", gate_en, 2'b01);
    retry = 1; tick(); retry = 0; settle();
    chk("R8 retry", gate_en, 2'b11);
    chk("R8 fault_n", fault_n, 1);
    do_read(6'h20);
  endtask

  task automatic t_clear();
    short_flag = 2'b11; ot_flag = 2'b10; tick();
    short_flag = 0; ot_flag = 0; tick(); settle();
    chk("R9 pre", gate_en, 0);
    supply_fail = 1; tick(); supply_fail = 0; settle();
    chk("R9 supply_fail gates", gate_en, 2'b11);
    chk("R9 supply_fail status", flt_status, 0);
    chk("R9 fault_n", fault_n, 1);
    uv_recov = 0; uv_flag = 1; tick(); uv_flag = 0; uv_recov = 1; tick(); settle();
    chk("R9 uv held", gate_en, 0);
    pwr_on_clr = 1; tick(); pwr_on_clr = 0; settle();
    chk("R9 por gates", gate_en, 2'b11);
    chk("R9 por status", flt_status, 0);
  endtask

  task automatic t_read_live();
    short_flag = 2'b01; tick();
    rd_strobe = 1; tick(); rd_strobe = 0; settle();
    chk("R10 snap live", rd_data, 6'h01);
    chk("R10 live kept", flt_status, 6'h01);
    short_flag = 0;
    supply_fail = 1; tick(); supply_fail = 0; settle();
    chk("R9 final clear", flt_status, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_short();
        t_unarmed();
        t_ot();
        t_ov_on();
        t_ov_off();
        t_uv_cmd_off();
        t_uv_cmd_on();
        t_clear();
        t_read_live();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule